// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth-Bit Address Filter

This block is a full-duplex serial port with four operating modes, picked by a two-bit mode input. Mode 0 is a synchronous shift register. It drives its own shift clock and exchanges eight bits, least significant first, at a fixed twelfth of the system clock. Mode 1 is an asynchronous 8-bit frame. Modes 2 and 3 are asynchronous 9-bit frames that carry an extra ninth bit. Mode 2 runs at a fixed division of the system clock, and modes 1 and 3 take their rate from an external overflow tick.

Every asynchronous frame is LSB first, with one start bit of 0 and one stop bit of 1. The receiver oversamples each bit 16 times. It takes three samples at the middle of the bit and keeps the majority value. A start bit that is no longer low at mid-bit counts as a glitch, and the receiver goes back to idle.

Transmit data enters through a valid/ready handshake. `tx_ready` is high only while the transmitter is idle. A byte is taken on the clock edge where `tx_valid` and `tx_ready` are both high, and `tx_data` and `tx_bit9` are sampled on that edge only. After that, `tx_ready` stays low until the last bit of the frame has gone out. A `tx_valid` that arrives while the port is busy is ignored: it is neither queued nor able to corrupt the frame on the line. The source may hold `tx_valid` high until it sees `tx_ready`. The transmit-done and receive-done flags stay set until the matching clear input is pulsed. A flag that is being set wins over a clear in the same cycle.

Top module: `sport_top`

## Requirements
- R1: After reset, the port is in the following state:
  - `tx_ready` = 1, `ser_out` = 1, `shift_clk` = 1
  - `tx_done` = 0, `rx_done` = 0
  - `rx_data` = 0, `rx_bit9` = 0
- R2: Mode 0 (`mode` = 2'b00) behaves as a synchronous shift register:
  - Each bit lasts 12 clocks.
  - `shift_clk` is low for the first 6 clocks of each bit and high for the last 6.
  - `ser_out` carries `tx_data` LSB first.
  - `ser_in` is sampled in the high half of each bit.
  - After the 8th bit, `tx_done` is set. If `rx_en` = 1, the eight sampled bits (first sample in bit 0) are loaded into `rx_data` and `rx_done` is set.
  - Outside mode 0, `shift_clk` stays high.
- R3: Mode 2 (`mode` = 2'b10) sends an 11-bit frame: start bit, 8 data bits, `tx_bit9`, stop bit. The bit time is 64 clocks when `dbl_rate` = 0 and 32 clocks when `dbl_rate` = 1.
- R4: Modes 1 and 3 take their rate from `ovf_tick`. The bit time is 32 overflow ticks when `dbl_rate` = 0 and 16 ticks when `dbl_rate` = 1.
  - Mode 1 (2'b01) sends a 10-bit frame: start bit, 8 data bits, stop bit.
  - Mode 3 (2'b11) sends the same 11-bit frame as mode 2.
- R5: In the asynchronous modes, `tx_done` rises at the start of the stop bit: it is still 0 during the preceding bit and 1 during the stop bit.
- R6: In mode 1, a received frame loads the 8 data bits into `rx_data` and the stop bit into `rx_bit9`. `rx_done` rises during the stop bit, not before it.
- R7: In modes 2 and 3, a received frame loads the 8 data bits into `rx_data` and the received ninth bit into `rx_bit9`.
- R8: In modes 2 and 3 with `mp_en` = 1, a frame whose ninth bit is 0 leaves `rx_done`, `rx_data` and `rx_bit9` unchanged. A frame whose ninth bit is 1 is accepted.
- R9: In mode 1, a stop bit received as 0 has two outcomes:
  - With `mp_en` = 1, the frame is dropped, with no flag and no data update.
  - With `mp_en` = 0, the frame is accepted and `rx_bit9` = 0.
- R10: While `rx_en` = 0, nothing on `ser_in` sets `rx_done` or changes `rx_data`.
- R11: `tx_done` and `rx_done` stay set until `tx_done_clr` or `rx_done_clr` is pulsed. A one-cycle pulse clears the flag.
- R12: A low pulse on `ser_in` that ends before the middle of the start bit is rejected. No flag is set, and a following valid frame is received correctly.
- R13: `tx_ready` falls in the cycle after a handshake and rises again only after the stop bit ends. A `tx_valid` raised while busy does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 shift, 01 8-bit async, 10 9-bit fixed rate, 11 9-bit tick rate |
| dbl_rate | input | 1 | Doubles the bit rate in modes 1, 2 and 3 |
| mp_en | input | 1 | Multiprocessor address filter enable |
| rx_en | input | 1 | Receive enable |
| tx_bit9 | input | 1 | Ninth bit sent in modes 2 and 3 |
| ovf_tick | input | 1 | One-cycle overflow pulse from an external rate timer |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle, ready to accept a byte |
| ser_out | output | 1 | Serial data out, idle high |
| shift_clk | output | 1 | Shift clock for mode 0, high when not shifting |
| tx_done | output | 1 | Sticky transmit-done flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| ser_in | input | 1 | Serial data in |
| rx_data | output | 8 | Last accepted received byte |
| rx_bit9 | output | 1 | Captured ninth bit or stop bit |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_done_clr | input | 1 | Clears `rx_done` |

## Verification
The hardest outcomes to reach from the ports are the frames the receiver must drop: a 9-bit frame with a zero ninth bit under the address filter, a mode-1 frame with a bad stop bit, and a start glitch shorter than half a bit. None of these produces any output change by itself. The bench drives `ser_in` bit by bit at the exact bit time, so it can place a wrong ninth or stop bit, or a short low pulse, where it chooses. It then checks that the flag, the data and the ninth bit keep the values of the previous accepted frame.

A mode-1 frame with a zero stop bit also leaves the line low just after the receiver returns to idle. This exercises the glitch path a second time.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } sp_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sport_baud.sv
`timescale 1ns/1ps
// Oversample tick (16 per bit) for the asynchronous modes.
module sport_baud #(
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dbl,
  input  logic       ovf_tick,
  output logic       ovs_tick
);
  import sport_pkg::*;

  localparam int SLOW_DIV = 2 * FAST_DIV;
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] pre;
  logic [CW-1:0] pre_last;
  logic          half;

  assign pre_last = dbl ? FAST_LAST : SLOW_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      half <= 1'b0;
    end else begin
      if (mode == MODE_UART9F && pre < pre_last) pre <= pre + 1'b1;
      else                                       pre <= '0;
      if (ovf_tick) half <= ~half;
    end
  end

  always_comb begin
    ovs_tick = 1'b0;
    if (mode == MODE_UART9F)
      ovs_tick = (pre >= pre_last);
    else if (mode == MODE_UART8 || mode == MODE_UART9V)
      ovs_tick = ovf_tick && (dbl || half);
  end
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
// Transmit engine shared by the shift mode and the asynchronous modes.
module sport_tx #(
  parameter int SHIFT_DIV = 12,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tx_bit9,
  input  logic       ovs_tick,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       ser_out,
  output logic       shift_clk,
  output logic       done_set,
  output logic       m0_sample,
  output logic       m0_end
);
  import sport_pkg::*;

  localparam int SPAN = (SHIFT_DIV > OVS) ? SHIFT_DIV : OVS;
  localparam int CW   = $clog2(SPAN);
  localparam logic [CW-1:0] M0_LAST = CW'(SHIFT_DIV - 1);
  localparam logic [CW-1:0] M0_HALF = CW'(SHIFT_DIV / 2);
  localparam logic [CW-1:0] M0_SAMP = CW'((SHIFT_DIV * 2) / 3);
  localparam logic [CW-1:0] AS_LAST = CW'(OVS - 1);

  logic          busy;
  logic [10:0]   sh;
  logic [3:0]    left;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          m0;
  logic          tick;
  logic          bit_end;

  assign m0      = (mode == MODE_SHIFT);
  assign tick    = m0 | ovs_tick;
  assign last    = m0 ? M0_LAST : AS_LAST;
  assign bit_end = busy && tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
    end else if (!busy) begin
      if (tx_valid) begin
        busy <= 1'b1;
        cnt  <= '0;
        case (mode)
          MODE_SHIFT: begin sh <= {3'b111, tx_data};         left <= 4'd8;  end
          MODE_UART8: begin sh <= {2'b11, tx_data, 1'b0};     left <= 4'd10; end
          default:    begin sh <= {1'b1, tx_bit9, tx_data, 1'b0}; left <= 4'd11; end
        endcase
      end
    end else if (tick) begin
      if (cnt == last) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign tx_ready  = !busy;
  assign ser_out   = busy ? sh[0] : 1'b1;
  assign shift_clk = !(busy && m0 && cnt < M0_HALF);
  assign done_set  = bit_end && (m0 ? (left == 4'd1) : (left == 4'd2));
  assign m0_sample = busy && m0 && (cnt == M0_SAMP);
  assign m0_end    = bit_end && m0 && (left == 4'd1);
endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
// Receive engine: majority-vote async receiver plus shift-mode capture.
module sport_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       mp_en,
  input  logic       ovs_tick,
  input  logic       ser_in,
  input  logic       m0_sample,
  input  logic       m0_end,
  input  logic       clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_done
);
  import sport_pkg::*;

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] S_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_MID = CW'(OVS / 2);
  localparam logic [CW-1:0] S_B   = CW'(OVS / 2 + 1);

  rx_state_e     state;
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0]    nbit;
  logic [3:0]    nlast;
  logic [8:0]    sh;
  logic [1:0]    smp;
  logic          maj;
  logic          m0;
  logic          ld;
  logic          ld_b9;
  logic [7:0]    ld_data;

  assign m0    = (mode == MODE_SHIFT);
  assign nlast = (mode == MODE_UART8) ? 4'd7 : 4'd8;
  assign maj   = (smp[1] & smp[0]) | (smp[1] & s2) | (smp[0] & s2);

  always_comb begin
    ld      = 1'b0;
    ld_data = sh[8:1];
    ld_b9   = rx_bit9;
    if (m0) begin
      ld = rx_en && m0_end;
    end else if (state == RX_STOP && rx_en && ovs_tick && cnt == S_B) begin
      if (mode == MODE_UART8) begin
        ld_b9 = maj;
        ld    = !mp_en || maj;
      end else begin
        ld_data = sh[7:0];
        ld_b9   = sh[8];
        ld      = !mp_en || sh[8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      state   <= RX_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      sh      <= '0;
      smp     <= '0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
      if (ld) begin
        rx_data <= ld_data;
        rx_bit9 <= ld_b9;
        rx_done <= 1'b1;
      end else if (clr) begin
        rx_done <= 1'b0;
      end
      if (m0) begin
        state <= RX_IDLE;
        if (rx_en && m0_sample) sh <= {s2, sh[8:1]};
      end else if (!rx_en) begin
        state <= RX_IDLE;
      end else if (ovs_tick) begin
        if (state == RX_IDLE) begin
          if (!s2) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end else begin
          if (cnt == S_A || cnt == S_MID) smp <= {smp[0], s2};
          if (cnt == LAST) cnt <= '0;
          else             cnt <= cnt + 1'b1;
          if (cnt == S_B) begin
            case (state)
              RX_START: begin
                if (maj) state <= RX_IDLE;
                else begin
                  state <= RX_DATA;
                  nbit  <= '0;
                end
              end
              RX_DATA: begin
                sh   <= {maj, sh[8:1]};
                nbit <= nbit + 4'd1;
                if (nbit == nlast) state <= RX_STOP;
              end
              default: state <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/sport_top.sv
`timescale 1ns/1ps
module sport_top #(
  parameter int SHIFT_DIV = 12,
  parameter int OVS       = 16,
  parameter int FAST_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dbl_rate,
  input  logic       mp_en,
  input  logic       rx_en,
  input  logic       tx_bit9,
  input  logic       ovf_tick,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       ser_out,
  output logic       shift_clk,
  output logic       tx_done,
  input  logic       tx_done_clr,
  input  logic       ser_in,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_done,
  input  logic       rx_done_clr
);
  logic ovs_tick;
  logic done_set;
  logic m0_sample;
  logic m0_end;

  sport_baud #(.FAST_DIV(FAST_DIV)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .dbl      (dbl_rate),
    .ovf_tick (ovf_tick),
    .ovs_tick (ovs_tick)
  );

  sport_tx #(.SHIFT_DIV(SHIFT_DIV), .OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .tx_bit9   (tx_bit9),
    .ovs_tick  (ovs_tick),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .ser_out   (ser_out),
    .shift_clk (shift_clk),
    .done_set  (done_set),
    .m0_sample (m0_sample),
    .m0_end    (m0_end)
  );

  sport_rx #(.OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rx_en     (rx_en),
    .mp_en     (mp_en),
    .ovs_tick  (ovs_tick),
    .ser_in    (ser_in),
    .m0_sample (m0_sample),
    .m0_end    (m0_end),
    .clr       (rx_done_clr),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .rx_done   (rx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_done <= 1'b0;
    else if (done_set)    tx_done <= 1'b1;
    else if (tx_done_clr) tx_done <= 1'b0;
  end
endmodule

// File: rtl/sport_checker.sv
`timescale 1ns/1ps
module sport_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       ser_out,
  input logic       shift_clk,
  input logic       tx_done,
  input logic       tx_done_clr,
  input logic       rx_done,
  input logic       rx_done_clr,
  input logic [7:0] rx_data
);
  p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ser_out && shift_clk);

  p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b00 |-> shift_clk);

  p_stop_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) && mode != 2'b00 |-> ser_out && !tx_ready);

  p_txdone_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_done_clr |=> tx_done);

  p_rxdone_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_done_clr |=> rx_done);

  p_data_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_done);
endmodule

bind sport_top sport_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .ser_out     (ser_out),
  .shift_clk   (shift_clk),
  .tx_done     (tx_done),
  .tx_done_clr (tx_done_clr),
  .rx_done     (rx_done),
  .rx_done_clr (rx_done_clr),
  .rx_data     (rx_data)
);

// File: tb/sport_top_bench.sv
`timescale 1ns/1ps
module sport_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       dbl_rate = 1'b0;
  logic       mp_en = 1'b0;
  logic       rx_en = 1'b0;
  logic       tx_bit9 = 1'b0;
  logic       ovf_tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       ser_out;
  logic       shift_clk;
  logic       tx_done;
  logic       tx_done_clr = 1'b0;
  logic       ser_in = 1'b1;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       rx_done;
  logic       rx_done_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  int ovf_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  logic       last_b9 = 1'b0;

  always #2.5 clk = ~clk;

  // Overflow tick every 3 clocks.
  always @(negedge clk) begin
    if (ovf_cnt == 2) begin ovf_cnt <= 0; ovf_tick <= 1'b1; end
    else begin ovf_cnt <= ovf_cnt + 1; ovf_tick <= 1'b0; end
  end

  sport_top u_sport_top (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl_rate(dbl_rate), .mp_en(mp_en),
    .rx_en(rx_en), .tx_bit9(tx_bit9), .ovf_tick(ovf_tick), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .ser_out(ser_out), .shift_clk(shift_clk),
    .tx_done(tx_done), .tx_done_clr(tx_done_clr), .ser_in(ser_in), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_done_clr(rx_done_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic d, input logic mp, input logic re);
    mode = m; dbl_rate = d; mp_en = mp; rx_en = re;
    wait_clk(2);
  endtask

  task automatic clear_flags();
    tx_done_clr = 1'b1; rx_done_clr = 1'b1;
    wait_clk(1);
    tx_done_clr = 1'b0; rx_done_clr = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 ser_out", ser_out, 1);
    chk("R1 shift_clk", shift_clk, 1);
    chk("R1 tx_done", tx_done, 0);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 rx_bit9", rx_bit9, 0);
  endtask

  // Mode 0: shift out 8'hA5 while shifting in 8'h3C.
  task automatic test_shift_mode();
    logic [7:0] txv = 8'hA5;
    logic [7:0] rxv = 8'h3C;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b1);
    tx_data = txv; tx_valid = 1'b1;
    wait_clk(1);
    tx_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wait_clk(3);
      chk("R2 data bit", ser_out, txv[k]);
      chk("R2 clock low half", shift_clk, 0);
      ser_in = rxv[k];
      wait_clk(6);
      chk("R2 clock high half", shift_clk, 1);
      if (k == 7) chk("R2 done not early", tx_done, 0);
      wait_clk(3);
    end
    ser_in = 1'b1;
    chk("R2 tx_done", tx_done, 1);
    chk("R2 rx_done", rx_done, 1);
    chk("R2 rx_data", rx_data, rxv);
    chk("R2 ready", tx_ready, 1);
    last_rx = rxv;
    wait_clk(30);
    chk("R11 tx_done held", tx_done, 1);
    chk("R11 rx_done held", rx_done, 1);
    clear_flags();
    chk("R11 tx_done cleared", tx_done, 0);
    chk("R11 rx_done cleared", rx_done, 0);
  endtask

  task automatic tx_async(input string req, input logic [7:0] d, input logic b9,
                          input bit nine, input int bitclk, input bit inject);
    logic [10:0] fr;
    int nb;
    nb = nine ? 11 : 10;
    fr = nine ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    tx_data = d; tx_bit9 = b9; tx_valid = 1'b1;
    wait_clk(1);
    tx_valid = 1'b0;
    chk("R13 ready low after accept", tx_ready, 0);
    wait_clk(bitclk / 2);
    for (int k = 0; k < nb; k++) begin
      chk(req, ser_out, fr[k]);
      if (k == nb - 2) chk("R5 done before stop", tx_done, 0);
      if (k == nb - 1) begin
        chk("R5 done in stop", tx_done, 1);
        chk("R13 busy in stop", tx_ready, 0);
      end
      if (inject && k == 3) begin
        tx_data = ~d; tx_valid = 1'b1;
        wait_clk(1);
        tx_valid = 1'b0;
        wait_clk(bitclk - 1);
      end else begin
        wait_clk(bitclk);
      end
    end
    chk("R13 ready after frame", tx_ready, 1);
    chk("R13 line idle", ser_out, 1);
    clear_flags();
  endtask

  task automatic test_tx_modes();
    set_cfg(2'b10, 1'b0, 1'b0, 1'b0);
    tx_async("R3 mode2 slow", 8'h5A, 1'b1, 1'b1, 64, 1'b1);
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0);
    tx_async("R3 mode2 fast", 8'hC3, 1'b0, 1'b1, 32, 1'b0);
    set_cfg(2'b01, 1'b0, 1'b0, 1'b0);
    tx_async("R4 mode1 slow", 8'h96, 1'b0, 1'b0, 96, 1'b0);
    set_cfg(2'b01, 1'b1, 1'b0, 1'b0);
    tx_async("R4 mode1 fast", 8'h69, 1'b0, 1'b0, 48, 1'b0);
    set_cfg(2'b11, 1'b1, 1'b0, 1'b0);
    tx_async("R4 mode3 fast", 8'h0F, 1'b1, 1'b1, 48, 1'b0);
  endtask

  task automatic rx_async(input string req, input logic [7:0] d, input logic b9,
                          input bit nine, input logic stopv, input int bitclk,
                          input bit acc, input logic exp_b9);
    ser_in = 1'b0;
    wait_clk(bitclk);
    for (int i = 0; i < 8; i++) begin
      ser_in = d[i];
      wait_clk(bitclk);
    end
    if (nine) begin
      ser_in = b9;
      wait_clk(bitclk);
    end
    chk({req, " no flag before stop"}, rx_done, 0);
    ser_in = stopv;
    wait_clk(bitclk);
    ser_in = 1'b1;
    wait_clk(bitclk);
    if (acc) begin
      last_rx = d;
      last_b9 = exp_b9;
    end
    chk({req, " flag"}, rx_done, acc);
    chk({req, " data"}, rx_data, last_rx);
    chk({req, " bit9"}, rx_bit9, last_b9);
    clear_flags();
  endtask

  task automatic test_rx_mode1();
    set_cfg(2'b01, 1'b1, 1'b0, 1'b1);
    rx_async("R6 mode1 good", 8'hB4, 1'b0, 1'b0, 1'b1, 48, 1'b1, 1'b1);
    rx_async("R9 mode1 bad stop open", 8'h5C, 1'b0, 1'b0, 1'b0, 48, 1'b1, 1'b0);
    set_cfg(2'b01, 1'b1, 1'b1, 1'b1);
    rx_async("R9 mode1 bad stop filtered", 8'hE7, 1'b0, 1'b0, 1'b0, 48, 1'b0, 1'b0);
    rx_async("R9 mode1 good stop filtered", 8'h18, 1'b0, 1'b0, 1'b1, 48, 1'b1, 1'b1);
  endtask

  task automatic test_rx_nine();
    set_cfg(2'b11, 1'b1, 1'b0, 1'b1);
    rx_async("R7 mode3 bit9", 8'h4D, 1'b1, 1'b1, 1'b1, 48, 1'b1, 1'b1);
    set_cfg(2'b11, 1'b1, 1'b1, 1'b1);
    rx_async("R8 mode3 filtered", 8'h22, 1'b0, 1'b1, 1'b1, 48, 1'b0, 1'b0);
    rx_async("R8 mode3 address", 8'h71, 1'b1, 1'b1, 1'b1, 48, 1'b1, 1'b1);
    set_cfg(2'b10, 1'b1, 1'b0, 1'b1);
    rx_async("R7 mode2 bit9", 8'h3A, 1'b0, 1'b1, 1'b1, 32, 1'b1, 1'b0);
    set_cfg(2'b10, 1'b1, 1'b1, 1'b1);
    rx_async("R8 mode2 filtered", 8'h99, 1'b0, 1'b1, 1'b1, 32, 1'b0, 1'b0);
  endtask

  task automatic test_rx_disabled();
    set_cfg(2'b01, 1'b1, 1'b0, 1'b0);
    rx_async("R10 disabled", 8'hC6, 1'b0, 1'b0, 1'b1, 48, 1'b0, 1'b0);
  endtask

  task automatic test_glitch();
    set_cfg(2'b10, 1'b1, 1'b0, 1'b1);
    ser_in = 1'b0;
    wait_clk(6);
    ser_in = 1'b1;
    wait_clk(64);
    chk("R12 glitch no flag", rx_done, 0);
    chk("R12 glitch data kept", rx_data, last_rx);
    rx_async("R12 frame after glitch", 8'hE1, 1'b1, 1'b1, 1'b1, 32, 1'b1, 1'b1);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(1);
    test_reset();
    test_shift_mode();
    test_tx_modes();
    test_rx_mode1();
    test_rx_nine();
    test_rx_disabled();
    test_glitch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule